// File: doc/BRIEF.md
# Compressed Halfword Instruction Decoder

This block turns a stream of 16-bit compressed instruction halfwords into one wide decoded record per complete instruction. The record gives an operation class, up to two architectural source register indices, a destination index, a final immediate, an access size, a small function code, and flags for two-halfword and illegal forms. Execution, register reads and memory access are left to the stages downstream.

Some instructions take two halfwords. A leading prefix halfword widens the immediate of the instruction that follows it. The decoder holds that prefix and merges its split immediate fields with the low bits of the next halfword. Without a prefix, memory offsets are scaled by the access size. With a prefix, they are used unscaled. A jump-and-link instruction always spans two halfwords, and its second halfword is raw target data.

Three-bit register fields are widened to architectural indices: field values 0 and 1 map to a configurable base and the register after it. Input is a valid/ready halfword stream. Output is a registered valid/ready record.

Top module: `cdx_decoder`

## Requirements
- R1: A halfword whose bits [15:11] are 11110 is a prefix. When no halfword is held, it is accepted and stored, and it produces no record. It always joins the next accepted halfword to form one instruction.
- R2: With a prefix p held, the next halfword h in the general extendable forms has the immediate {p[4:0], p[10:5], h[4:0]}, sign-extended to IMM_W bits. The flag out_ext is 1. This covers the accumulator add, opcode 01001 (class 2, fn 2, source and destination both map(h[10:8])).
- R3: With a prefix, the three-register add (opcode 01000, class 2) has the immediate {p[3:0], p[10:4], h[3:0]}, sign-extended from bit 14.
- R4: A 3-bit register field f maps to REMAP_BASE+f when f is 0 or 1, and to f otherwise. With the defaults, 0 maps to 16 and 1 maps to 17.
- R5: For a shift (opcode 00110, class 3, source map(h[7:5]), destination map(h[10:8]), fn {000,h[1:0]}), the shift amount goes in the immediate field. Without a prefix it is h[4:2], except that a field of 0 gives 8. With a prefix it is the 6-bit value {p[5], p[10:6]}.
- R6: Without a prefix, a load (class 0, base map(h[10:8]), destination map(h[7:5])) or a store (class 1, base map(h[10:8]), data map(h[7:5]), destination 0) has the offset h[4:0] zero-extended and multiplied by the access size. The size code is 0 for byte, 1 for half, 2 for word and 3 for double. The opcodes are: loads 10000, 10001, 10011, 00111; stores 11000, 11001, 11011, 01111.
- R7: With a prefix, a load or store uses the R2 immediate, sign-extended and unscaled.
- R8: Opcode 00011 starts a jump-and-link that spans two halfwords. It gives class 5, destination LINK_REG, fn {0000, h1[10]} and out_ext 1. The immediate is {h1[4:0], h1[9:5], h2[15:0]}, zero-extended. The second halfword is never decoded on its own, even if it looks like a prefix.
- R9: A prefix followed by another prefix, by 00011, by 11101 or by an unsupported opcode produces one record. That record has out_illegal 1, class 7, and every other field 0. Both halfwords are consumed.
- R10: An unsupported opcode with no prefix produces the same illegal record.
- R11: in_ready equals !out_valid || out_ready. A record that is not yet taken keeps all its fields unchanged.
- R12: A synchronous reset clears out_valid and discards any held prefix or held first jump halfword.
- R13: Without a prefix, opcode 01000 takes the sign-extended h[3:0] as its immediate, with destination map(h[7:5]) and fn {0000,h[4]}. Opcode 01001 takes the sign-extended h[7:0].
- R14: Opcode 11101 without a prefix is a register-register operation. It gives class 4, sources map(h[10:8]) and map(h[7:5]), destination map(h[10:8]), fn h[4:0] and immediate 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Halfword offered |
| in_ready | output | 1 | Halfword accepted this cycle when in_valid is also high |
| in_hw | input | 16 | Instruction halfword |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Downstream takes the record |
| out_cls | output | 3 | Operation class |
| out_src_a | output | REG_W | First source / base register |
| out_src_b | output | REG_W | Second source / store data register |
| out_dst | output | REG_W | Destination register |
| out_imm | output | IMM_W | Final immediate |
| out_size | output | 2 | Access size code |
| out_fn | output | 5 | Function / variant code |
| out_ext | output | 1 | Record built from two halfwords |
| out_illegal | output | 1 | Illegal sequence or opcode |

## Verification
The bench builds the decoder with IMM_W set to 36 rather than 32. This makes every sign-extension path visible in the bits above the widest field, so a truncated or zero-filled extension shows up in the top nibble. REG_W and REMAP_BASE keep their defaults of 5 and 16. With those values the remapped indices 16 and 17 sit apart from the identity range 2 to 7. The random stream includes prefixes often enough that back-to-back prefixes, prefixed jumps and jump halves that resemble prefixes all occur under random backpressure.

// File: rtl/cdx_pkg.sv
package cdx_pkg;

   typedef enum logic [2:0] {
      CLS_LOAD  = 3'd0,
      CLS_STORE = 3'd1,
      CLS_ALUI  = 3'd2,
      CLS_SHIFT = 3'd3,
      CLS_ALUR  = 3'd4,
      CLS_JUMP  = 3'd5,
      CLS_BAD   = 3'd7
   } cls_e;

   typedef enum logic [1:0] {
      HOLD_NONE = 2'd0,
      HOLD_EXT  = 2'd1,
      HOLD_JAL  = 2'd2
   } hold_e;

   typedef enum logic [2:0] {
      IMM_ZERO  = 3'd0,
      IMM_MEM   = 3'd1,
      IMM_ADD3  = 3'd2,
      IMM_ADD8  = 3'd3,
      IMM_SHIFT = 3'd4,
      IMM_JAL   = 3'd5
   } imm_e;

   localparam logic [4:0] OP_PREFIX = 5'b11110;
   localparam logic [4:0] OP_JAL    = 5'b00011;
   localparam logic [4:0] OP_RR     = 5'b11101;
   localparam logic [4:0] OP_SHIFT  = 5'b00110;
   localparam logic [4:0] OP_ADD3   = 5'b01000;
   localparam logic [4:0] OP_ADD8   = 5'b01001;
   localparam logic [4:0] OP_LB     = 5'b10000;
   localparam logic [4:0] OP_LH     = 5'b10001;
   localparam logic [4:0] OP_LW     = 5'b10011;
   localparam logic [4:0] OP_LD     = 5'b00111;
   localparam logic [4:0] OP_SB     = 5'b11000;
   localparam logic [4:0] OP_SH     = 5'b11001;
   localparam logic [4:0] OP_SW     = 5'b11011;
   localparam logic [4:0] OP_SD     = 5'b01111;

endpackage

// File: rtl/cdx_regmap.sv
module cdx_regmap #(
   parameter int REG_W      = 5,
   parameter int REMAP_BASE = 16
) (
   input  logic [2:0]       fld,
   output logic [REG_W-1:0] arch
);
   // low two field codes are relocated to the remap window
   assign arch = (fld < 3'd2) ? (REG_W'(REMAP_BASE) + REG_W'(fld)) : REG_W'(fld);
endmodule

// File: rtl/cdx_imm_build.sv
module cdx_imm_build
   import cdx_pkg::*;
#(
   parameter int IMM_W = 32
) (
   input  imm_e             sel,
   input  logic             has_pre,
   input  logic [1:0]       sz,
   input  logic [10:0]      pre,
   input  logic [15:0]      hw,
   output logic [IMM_W-1:0] imm
);
   localparam int PAD16 = IMM_W - 16;
   localparam int PAD15 = IMM_W - 15;
   localparam int PAD8  = IMM_W - 8;
   localparam int PAD4  = IMM_W - 4;

   logic [15:0] wide16;
   logic [14:0] wide15;
   logic [5:0]  sh_ext;
   logic [25:0] tgt;

   // fields are reassembled out of their transmitted order
   assign wide16 = {pre[4:0], pre[10:5], hw[4:0]};
   assign wide15 = {pre[3:0], pre[10:4], hw[3:0]};
   assign sh_ext = {pre[5], pre[10:6]};
   assign tgt    = {pre[4:0], pre[9:5], hw};

   always_comb begin
      case (sel)
         IMM_MEM:   imm = has_pre ? {{PAD16{wide16[15]}}, wide16}
                                  : (IMM_W'(hw[4:0]) << sz);
         IMM_ADD3:  imm = has_pre ? {{PAD15{wide15[14]}}, wide15}
                                  : {{PAD4{hw[3]}}, hw[3:0]};
         IMM_ADD8:  imm = has_pre ? {{PAD16{wide16[15]}}, wide16}
                                  : {{PAD8{hw[7]}}, hw[7:0]};
         IMM_SHIFT: imm = has_pre ? IMM_W'(sh_ext)
                                  : ((hw[4:2] == 3'd0) ? IMM_W'(8) : IMM_W'(hw[4:2]));
         IMM_JAL:   imm = IMM_W'(tgt);
         default:   imm = '0;
      endcase
   end
endmodule

// File: rtl/cdx_seq.sv
module cdx_seq
   import cdx_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        acc,
   input  logic [15:0] hw,
   output hold_e       kind,
   output logic [10:0] held,
   output logic        issue
);
   logic is_pre;
   logic is_jal;

   assign is_pre = (hw[15:11] == OP_PREFIX);
   assign is_jal = (hw[15:11] == OP_JAL);

   // a leading halfword is absorbed; anything else closes an instruction
   assign issue = acc && !((kind == HOLD_NONE) && (is_pre || is_jal));

   always_ff @(posedge clk) begin
      if (rst) begin
         kind <= HOLD_NONE;
         held <= '0;
      end else if (acc) begin
         if (kind == HOLD_NONE && is_pre) begin
            kind <= HOLD_EXT;
            held <= hw[10:0];
         end else if (kind == HOLD_NONE && is_jal) begin
            kind <= HOLD_JAL;
            held <= hw[10:0];
         end else begin
            kind <= HOLD_NONE;
         end
      end
   end

   AST_PAIR_CLOSES: assert property (@(posedge clk) disable iff (rst)
      (acc && kind != HOLD_NONE) |=> (kind == HOLD_NONE)); // R1
endmodule

// File: rtl/cdx_decoder.sv
module cdx_decoder
   import cdx_pkg::*;
#(
   parameter int IMM_W      = 32,
   parameter int REG_W      = 5,
   parameter int REMAP_BASE = 16,
   parameter int LINK_REG   = 31
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [15:0]      in_hw,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [2:0]       out_cls,
   output logic [REG_W-1:0] out_src_a,
   output logic [REG_W-1:0] out_src_b,
   output logic [REG_W-1:0] out_dst,
   output logic [IMM_W-1:0] out_imm,
   output logic [1:0]       out_size,
   output logic [4:0]       out_fn,
   output logic             out_ext,
   output logic             out_illegal
);
   localparam int NUM_FLD = 2;
   localparam int REG_CNT = 1 << REG_W;

   if (IMM_W < 26) begin : g_chk_imm
      $error("IMM_W must hold the 26-bit jump target");
   end
   if (REG_W < 3) begin : g_chk_reg
      $error("REG_W must cover a 3-bit field");
   end
   if (REMAP_BASE + 1 >= REG_CNT || LINK_REG >= REG_CNT) begin : g_chk_map
      $error("REMAP_BASE or LINK_REG outside the register space");
   end

   logic             acc;
   logic             issue;
   logic             has_pre;
   hold_e            kind;
   logic [10:0]      held;
   logic [4:0]       op;
   logic [REG_W-1:0] mapped [NUM_FLD];
   logic [IMM_W-1:0] n_imm;

   cls_e             n_cls;
   imm_e             n_sel;
   logic [1:0]       n_sz;
   logic [4:0]       n_fn;
   logic [REG_W-1:0] n_a, n_b, n_d;
   logic             n_ext, n_bad;

   cls_e             r_cls;

   assign in_ready = !out_valid || out_ready;
   assign acc      = in_valid && in_ready;
   assign op       = in_hw[15:11];
   assign has_pre  = (kind == HOLD_EXT);

   cdx_seq u_seq (
      .clk   (clk),
      .rst   (rst),
      .acc   (acc),
      .hw    (in_hw),
      .kind  (kind),
      .held  (held),
      .issue (issue)
   );

   // field 0 = bits [10:8], field 1 = bits [7:5]
   for (genvar gi = 0; gi < NUM_FLD; gi++) begin : g_map
      cdx_regmap #(.REG_W(REG_W), .REMAP_BASE(REMAP_BASE)) u_map (
         .fld  (in_hw[10-3*gi -: 3]),
         .arch (mapped[gi])
      );
   end

   always_comb begin
      n_cls = CLS_BAD;
      n_sel = IMM_ZERO;
      n_sz  = 2'd0;
      n_fn  = 5'd0;
      n_a   = '0;
      n_b   = '0;
      n_d   = '0;
      n_ext = has_pre;
      if (kind == HOLD_JAL) begin
         n_cls = CLS_JUMP;
         n_sel = IMM_JAL;
         n_d   = REG_W'(LINK_REG);
         n_fn  = {4'b0000, held[10]};
         n_ext = 1'b1;
      end else begin
         case (op)
            OP_LB, OP_LH, OP_LW, OP_LD: begin
               n_cls = CLS_LOAD;
               n_sel = IMM_MEM;
               n_a   = mapped[0];
               n_d   = mapped[1];
            end
            OP_SB, OP_SH, OP_SW, OP_SD: begin
               n_cls = CLS_STORE;
               n_sel = IMM_MEM;
               n_a   = mapped[0];
               n_b   = mapped[1];
            end
            OP_ADD3: begin
               n_cls = CLS_ALUI;
               n_sel = IMM_ADD3;
               n_a   = mapped[0];
               n_d   = mapped[1];
               n_fn  = {4'b0000, in_hw[4]};
            end
            OP_ADD8: begin
               n_cls = CLS_ALUI;
               n_sel = IMM_ADD8;
               n_a   = mapped[0];
               n_d   = mapped[0];
               n_fn  = 5'd2;
            end
            OP_SHIFT: begin
               n_cls = CLS_SHIFT;
               n_sel = IMM_SHIFT;
               n_a   = mapped[1];
               n_d   = mapped[0];
               n_fn  = {3'b000, in_hw[1:0]};
            end
            OP_RR: begin
               if (!has_pre) begin
                  n_cls = CLS_ALUR;
                  n_a   = mapped[0];
                  n_b   = mapped[1];
                  n_d   = mapped[0];
                  n_fn  = in_hw[4:0];
               end
            end
            default: n_cls = CLS_BAD;
         endcase
         case (op)
            OP_LB, OP_SB: n_sz = 2'd0;
            OP_LH, OP_SH: n_sz = 2'd1;
            OP_LW, OP_SW: n_sz = 2'd2;
            OP_LD, OP_SD: n_sz = 2'd3;
            default:      n_sz = 2'd0;
         endcase
      end
      n_bad = (n_cls == CLS_BAD);
      if (n_bad) begin
         n_sel = IMM_ZERO;
         n_sz  = 2'd0;
         n_fn  = 5'd0;
         n_a   = '0;
         n_b   = '0;
         n_d   = '0;
         n_ext = 1'b0;
      end
   end

   cdx_imm_build #(.IMM_W(IMM_W)) u_imm (
      .sel     (n_sel),
      .has_pre (has_pre),
      .sz      (n_sz),
      .pre     (held),
      .hw      (in_hw),
      .imm     (n_imm)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         r_cls       <= CLS_BAD;
         out_src_a   <= '0;
         out_src_b   <= '0;
         out_dst     <= '0;
         out_imm     <= '0;
         out_size    <= '0;
         out_fn      <= '0;
         out_ext     <= 1'b0;
         out_illegal <= 1'b0;
      end else if (issue) begin
         out_valid   <= 1'b1;
         r_cls       <= n_cls;
         out_src_a   <= n_a;
         out_src_b   <= n_b;
         out_dst     <= n_d;
         out_imm     <= n_imm;
         out_size    <= n_sz;
         out_fn      <= n_fn;
         out_ext     <= n_ext;
         out_illegal <= n_bad;
      end else if (out_ready) begin
         out_valid   <= 1'b0;
      end
   end

   assign out_cls = r_cls;

   AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready); // R11
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_imm) && $stable(out_cls)
                                     && $stable(out_dst) && $stable(out_illegal))); // R11
   AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (rst)
      (acc && kind == HOLD_NONE && op == OP_PREFIX) |=> !out_valid); // R1
   AST_REMAP_RANGE: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_cls == CLS_LOAD) |-> ((out_dst >= REG_W'(2) && out_dst <= REG_W'(7))
         || out_dst == REG_W'(REMAP_BASE) || out_dst == REG_W'(REMAP_BASE + 1))); // R4
   AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_cls == CLS_SHIFT && !out_ext)
         |-> (out_imm >= IMM_W'(1) && out_imm <= IMM_W'(8))); // R5
   AST_BAD_CLEAN: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_illegal) |-> (out_cls == CLS_BAD && out_imm == '0
                                      && out_dst == '0 && !out_ext)); // R9
   AST_SCALED_ALIGN: assert property (@(posedge clk) disable iff (rst)
      (out_valid && (out_cls == CLS_LOAD || out_cls == CLS_STORE) && !out_ext
       && out_size == 2'd3) |-> (out_imm[2:0] == 3'd0)); // R6
   AST_RESET_EMPTY: assert property (@(posedge clk)
      $past(rst) |-> !out_valid); // R12
endmodule

// File: tb/sim_cdx_decoder.sv
module sim_cdx_decoder;
   localparam int CLK_P   = 10;
   localparam int IMM_W   = 36;
   localparam int LIMIT   = 150000;

   typedef struct packed {
      logic [2:0]       cls;
      logic [4:0]       a;
      logic [4:0]       b;
      logic [4:0]       d;
      logic [IMM_W-1:0] imm;
      logic [1:0]       sz;
      logic [4:0]       fn;
      logic             ext;
      logic             bad;
   } rec_t;

   logic             clk = 1'b0;
   logic             rst;
   logic             in_valid;
   logic             in_ready;
   logic [15:0]      in_hw;
   logic             out_valid;
   logic             out_ready;
   logic [2:0]       out_cls;
   logic [4:0]       out_src_a, out_src_b, out_dst;
   logic [IMM_W-1:0] out_imm;
   logic [1:0]       out_size;
   logic [4:0]       out_fn;
   logic             out_ext, out_illegal;

   int    checks = 0;
   int    errors = 0;
   int    cyc    = 0;
   bit    run    = 0;
   bit    hung   = 0;
   int    m_kind = 0;
   logic [15:0] m_hw = '0;
   string m_note = "";
   logic [15:0] stim [$];
   rec_t  exp_q [$];
   string tag_q [$];
   rec_t  prev_rec;
   bit    prev_hold = 0;

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cdx_decoder #(.IMM_W(IMM_W)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_hw(in_hw),
      .out_valid(out_valid), .out_ready(out_ready), .out_cls(out_cls),
      .out_src_a(out_src_a), .out_src_b(out_src_b), .out_dst(out_dst),
      .out_imm(out_imm), .out_size(out_size), .out_fn(out_fn),
      .out_ext(out_ext), .out_illegal(out_illegal));

   function automatic rec_t cur_rec();
      return {out_cls, out_src_a, out_src_b, out_dst, out_imm, out_size, out_fn,
              out_ext, out_illegal};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [79:0] act,
                      input logic [79:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, expv, $time);
      end
   endtask

   function automatic logic [4:0] map3(input logic [2:0] f);
      return (f < 3'd2) ? 5'(16 + f) : {2'b00, f};
   endfunction

   // behavioural reference: consumes one accepted halfword
   task automatic model_take(input logic [15:0] h);
      rec_t r;
      string tag;
      logic [4:0] op;
      logic [15:0] p;
      bit pre;
      longint v;
      int sz;
      op = h[15:11];
      if (m_kind == 0 && op == 5'b11110) begin m_kind = 1; m_hw = h; return; end
      if (m_kind == 0 && op == 5'b00011) begin m_kind = 2; m_hw = h; return; end
      r = '0; pre = (m_kind == 1); p = m_hw; v = 0; sz = 0; tag = "";
      if (m_kind == 2) begin
         r.cls = 5; r.d = 5'd31; r.fn = {4'b0, p[10]}; r.ext = 1;
         v = longint'({p[4:0], p[9:5], h});
         tag = "R8";
      end else begin
         case (op)
            5'b10000, 5'b11000: sz = 0;
            5'b10001, 5'b11001: sz = 1;
            5'b10011, 5'b11011: sz = 2;
            default:            sz = 3;
         endcase
         case (op)
            5'b10000, 5'b10001, 5'b10011, 5'b00111,
            5'b11000, 5'b11001, 5'b11011, 5'b01111: begin
               r.cls = (op[4:3] == 2'b11 || op == 5'b01111) ? 3'd1 : 3'd0;
               r.a = map3(h[10:8]);
               if (r.cls == 0) r.d = map3(h[7:5]); else r.b = map3(h[7:5]);
               r.sz = 2'(sz);
               if (pre) begin
                  v = p[4:0] * 2048 + p[10:5] * 32 + h[4:0];
                  if (v >= 32768) v -= 65536;
                  tag = "R7 R4";
               end else begin
                  v = h[4:0] * (1 << sz);
                  tag = "R6 R4";
               end
            end
            5'b01000: begin
               r.cls = 2; r.a = map3(h[10:8]); r.d = map3(h[7:5]); r.fn = {4'b0, h[4]};
               if (pre) begin
                  v = p[3:0] * 2048 + p[10:4] * 16 + h[3:0];
                  if (v >= 16384) v -= 32768;
                  tag = "R3";
               end else begin
                  v = h[3:0]; if (v >= 8) v -= 16;
                  tag = "R13";
               end
            end
            5'b01001: begin
               r.cls = 2; r.a = map3(h[10:8]); r.d = map3(h[10:8]); r.fn = 5'd2;
               if (pre) begin
                  v = p[4:0] * 2048 + p[10:5] * 32 + h[4:0];
                  if (v >= 32768) v -= 65536;
                  tag = "R2";
               end else begin
                  v = h[7:0]; if (v >= 128) v -= 256;
                  tag = "R13";
               end
            end
            5'b00110: begin
               r.cls = 3; r.a = map3(h[7:5]); r.d = map3(h[10:8]); r.fn = {3'b0, h[1:0]};
               if (pre) v = p[5] * 32 + p[10:6];
               else     v = (h[4:2] == 3'd0) ? 8 : h[4:2];
               tag = "R5";
            end
            5'b11101: begin
               if (!pre) begin
                  r.cls = 4; r.a = map3(h[10:8]); r.b = map3(h[7:5]); r.d = map3(h[10:8]);
                  r.fn = h[4:0]; tag = "R14";
               end
            end
            default: ;
         endcase
         if (tag == "") begin
            r = '0; r.cls = 7; r.bad = 1; v = 0;
            tag = pre ? "R9" : "R10";
         end
         r.ext = r.bad ? 1'b0 : pre;
      end
      r.imm = v[IMM_W-1:0];
      exp_q.push_back(r);
      tag_q.push_back({tag, m_note});
      m_kind = 0;
   endtask

   always @(negedge clk) begin
      if (run && !rst) begin
         in_valid  = (stim.size() > 0) && ($urandom % 4 != 0);
         in_hw     = (stim.size() > 0) ? stim[0] : 16'h0;
         out_ready = ($urandom % 3 != 0);
         #1;
         chk(in_ready == (!out_valid || out_ready), "R11 ready",
             80'(in_ready), 80'(!out_valid || out_ready));
         if (prev_hold) begin
            chk(out_valid && cur_rec() == prev_rec, "R11 stable",
                80'(cur_rec()), 80'(prev_rec));
         end
         prev_hold = out_valid && !out_ready;
         prev_rec  = cur_rec();
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R1 spurious record", 80'(cur_rec()), 80'(0));
            end else begin
               rec_t e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(cur_rec() == e, t, 80'(cur_rec()), 80'(e));
            end
         end
         if (in_valid && in_ready) begin
            model_take(stim.pop_front());
         end
      end
   end

   task automatic drain();
      while ((stim.size() > 0 || exp_q.size() > 0 || out_valid) && cyc < LIMIT)
         @(negedge clk);
      if (cyc >= LIMIT) hung = 1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      run = 0; rst = 1; in_valid = 0; out_ready = 1;
      repeat (2) @(negedge clk);
      #1;
      chk(!out_valid && in_ready, "R12 reset state", 80'({out_valid, in_ready}), 80'(2'b01));
      m_kind = 0; exp_q.delete(); tag_q.delete(); prev_hold = 0;
      rst = 0;
   endtask

   initial begin
      rst = 1; in_valid = 0; in_hw = '0; out_ready = 0;
      do_reset();
      // directed patterns
      stim.push_back({5'b10000, 3'd0, 3'd1, 5'd7});
      stim.push_back({5'b10001, 3'd2, 3'd3, 5'd31});
      stim.push_back({5'b10011, 3'd7, 3'd0, 5'd5});
      stim.push_back({5'b00111, 3'd1, 3'd4, 5'd3});
      stim.push_back({5'b11011, 3'd2, 3'd5, 5'd1});
      stim.push_back({5'b01111, 3'd6, 3'd0, 5'd31});
      stim.push_back({5'b11110, 6'b111111, 5'b11111});
      stim.push_back({5'b10011, 3'd3, 3'd2, 5'b10000});
      stim.push_back({5'b11110, 6'b000011, 5'b01010});
      stim.push_back({5'b11001, 3'd1, 3'd0, 5'b00001});
      stim.push_back({5'b01000, 3'd3, 3'd4, 1'b0, 4'b1001});
      stim.push_back({5'b11110, 7'b1010101, 4'b1000});
      stim.push_back({5'b01000, 3'd0, 3'd1, 1'b1, 4'b0011});
      stim.push_back({5'b01001, 3'd5, 8'hF0});
      stim.push_back({5'b11110, 6'b100000, 5'b01111});
      stim.push_back({5'b01001, 3'd1, 3'd0, 5'b00110});
      stim.push_back({5'b00110, 3'd2, 3'd3, 3'b000, 2'b00});
      stim.push_back({5'b00110, 3'd0, 3'd6, 3'b101, 2'b11});
      stim.push_back({5'b11110, 5'b10101, 1'b1, 5'b00000});
      stim.push_back({5'b00110, 3'd4, 3'd1, 3'b000, 2'b01});
      stim.push_back({5'b11101, 3'd1, 3'd6, 5'b01100});
      stim.push_back({5'b00011, 1'b1, 5'b10101, 5'b01110});
      stim.push_back(16'hF7A5);
      stim.push_back({5'b11110, 11'h123});
      stim.push_back({5'b11110, 11'h456});
      stim.push_back({5'b11110, 11'h0AA});
      stim.push_back({5'b11101, 3'd2, 3'd2, 5'b00010});
      stim.push_back({5'b11110, 11'h001});
      stim.push_back({5'b00011, 11'h3FF});
      stim.push_back({5'b00100, 11'h0F0});
      stim.push_back({5'b11110, 11'h7FF});
      stim.push_back({5'b00010, 11'h011});
      run = 1;
      drain();
      // held prefix must not survive a reset
      stim.push_back({5'b11110, 11'h7FF});
      drain();
      do_reset();
      m_note = " R12";
      stim.push_back({5'b10001, 3'd4, 3'd5, 5'd9});
      run = 1;
      drain();
      m_note = "";
      // random stream, prefix-heavy
      for (int i = 0; i < 4000; i++) begin
         logic [15:0] h;
         h = 16'($urandom);
         if (i % 4 == 1) h[15:11] = 5'b11110;
         stim.push_back(h);
      end
      drain();
      if (hung) begin
         errors++;
         $display("FAIL watchdog: run did not drain, actual=%0d expected=%0d", cyc, LIMIT);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule